// File: doc/BRIEF.md
# Shift-Chained Register Stack

This block is a last-in, first-out store of a fixed number of words (four by default) kept in a line of registers. Each register feeds the one beneath it. A word written in always lands in the top register, and the read port always shows the top register. Nothing is addressed through a pointer: on every accepted operation the whole chain moves by one place, down for a push or up for a pop.

Two plain control pins pick the move. A push with no pop shifts the chain down and takes in the input word. A pop with no push shifts it up and fills the bottom with zero. Both pins high, or both low, leaves every register as it is.

A saturating occupancy count from 0 to the depth drives the empty and full flags. The flags only report the state and never stop an operation. There is no valid/ready handshake: every request is taken on the clock edge where it appears, so the block applies no back-pressure to the writer, and the top word is valid on every cycle.

Top module: `register_chain_stack`

## Requirements
- R1: While `rst` is 1 at a rising clock edge, all entries become zero and `level` becomes 0, whatever `push` and `pop` are. `dout` then reads 0, `empty` is 1 and `full` is 0.
- R2: An edge with `push`=1 and `pop`=0 loads `din` into the top entry, so `dout` equals that `din` after the edge.
- R3: On a push, every entry moves one place down the chain. Words therefore come back out in the reverse of the order they went in.
- R4: An edge with `pop`=1 and `push`=0 moves every entry one place up, so `dout` shows the word that was second from the top before the edge.
- R5: An edge with `push` and `pop` equal (both 0 or both 1) changes no entry and does not change `level`.
- R6: On a pop, the bottom entry loads zero. A pop from an empty stack therefore leaves `dout` at 0.
- R7: A push into a full stack silently drops the bottom word. After five pushes, four pops return the last four words and the next pop gives 0.
- R8: `level` counts accepted pushes minus pops, saturating at 0 and at DEPTH (4). `empty` is 1 exactly when `level` is 0, and `full` is 1 exactly when `level` is 4. Neither flag blocks a push or a pop.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| push | input | 1 | Shift the chain down and load `din` |
| pop | input | 1 | Shift the chain up, zero-fill the bottom |
| din | input | WIDTH (32) | Word loaded into the top entry on a push |
| dout | output | WIDTH (32) | Current top entry |
| level | output | $clog2(DEPTH+1) (3) | Occupancy count, 0 to DEPTH |
| empty | output | 1 | `level` is 0 |
| full | output | 1 | `level` is DEPTH |

## Verification
The shift is tried with a straight fill followed by a drain, so a wrong shift direction or a missing link in the chain shows up as words returned in the wrong order. An overfill with a fifth push separates dropping the bottom word from dropping the top one. Pops on an empty stack and a drain past a dropped word show whether the bottom really fills with zero. Cycles with both controls low and with both high, each given a distinct `din`, tell a true hold apart from one control quietly winning, and a reset asserted together with a push shows that reset takes priority.

// File: rtl/stack_pkg.sv
package stack_pkg;
  typedef enum logic [1:0] {
    MOVE_HOLD = 2'd0,
    MOVE_DOWN = 2'd1,
    MOVE_UP   = 2'd2
  } chain_move_e;
endpackage

// File: rtl/stack_move_decode.sv
module stack_move_decode
  import stack_pkg::*;
(
  input  logic        push,
  input  logic        pop,
  output chain_move_e move
);
  always_comb begin
    unique case ({push, pop})
      2'b10:   move = MOVE_DOWN;
      2'b01:   move = MOVE_UP;
      default: move = MOVE_HOLD;
    endcase
  end
endmodule

// File: rtl/stack_cell.sv
module stack_cell
  import stack_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  chain_move_e      move,
  input  logic [WIDTH-1:0] from_above,
  input  logic [WIDTH-1:0] from_below,
  output logic [WIDTH-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else begin
      unique case (move)
        MOVE_DOWN: q <= from_above;
        MOVE_UP:   q <= from_below;
        default:   q <= q;
      endcase
    end
  end
endmodule

// File: rtl/stack_level.sv
module stack_level
  import stack_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic        clk,
  input  logic        rst,
  input  chain_move_e move,
  output logic [LW-1:0] level,
  output logic        empty,
  output logic        full
);
  localparam logic [LW-1:0] TOP = LW'(DEPTH);

  always_ff @(posedge clk) begin
    if (rst) begin
      level <= '0;
    end else begin
      unique case (move)
        MOVE_DOWN: if (level != TOP) level <= level + 1'b1;
        MOVE_UP:   if (level != '0)  level <= level - 1'b1;
        default:   level <= level;
      endcase
    end
  end

  assign empty = (level == '0);
  assign full  = (level == TOP);
endmodule

// File: rtl/register_chain_stack.sv
module register_chain_stack
  import stack_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int DEPTH = 4,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic             pop,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout,
  output logic [LVL_W-1:0] level,
  output logic             empty,
  output logic             full
);
  chain_move_e move;
  logic [DEPTH-1:0][WIDTH-1:0] ent;

  stack_move_decode u_dec (
    .push (push),
    .pop  (pop),
    .move (move)
  );

  for (genvar i = 0; i < DEPTH; i++) begin : g_cell
    logic [WIDTH-1:0] above_w;
    logic [WIDTH-1:0] below_w;

    if (i == 0) begin : g_head
      assign above_w = din;
    end else begin : g_link_up
      assign above_w = ent[i-1];
    end

    if (i == DEPTH - 1) begin : g_tail
      assign below_w = '0;
    end else begin : g_link_dn
      assign below_w = ent[i+1];
    end

    stack_cell #(.WIDTH(WIDTH)) u_cell (
      .clk        (clk),
      .rst        (rst),
      .move       (move),
      .from_above (above_w),
      .from_below (below_w),
      .q          (ent[i])
    );
  end

  stack_level #(.DEPTH(DEPTH)) u_lvl (
    .clk   (clk),
    .rst   (rst),
    .move  (move),
    .level (level),
    .empty (empty),
    .full  (full)
  );

  assign dout = ent[0];
endmodule

// File: rtl/register_chain_stack_chk.sv
module register_chain_stack_chk #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 4,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input logic                        clk,
  input logic                        rst,
  input logic                        push,
  input logic                        pop,
  input logic [WIDTH-1:0]            din,
  input logic [WIDTH-1:0]            dout,
  input logic [LVL_W-1:0]            level,
  input logic                        empty,
  input logic                        full,
  input logic [DEPTH-1:0][WIDTH-1:0] ent
);
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (dout == '0 && level == '0 && empty && !full));

  a_r2_push_loads_top: assert property (@(posedge clk) disable iff (rst)
    (push && !pop) |=> (dout == $past(din)));

  a_r3_push_shifts_down: assert property (@(posedge clk) disable iff (rst)
    (push && !pop) |=> (ent[1] == $past(ent[0])));

  a_r4_pop_shifts_up: assert property (@(posedge clk) disable iff (rst)
    (pop && !push) |=> (dout == $past(ent[1])));

  a_r5_hold_on_tie: assert property (@(posedge clk) disable iff (rst)
    (push == pop) |=> ($stable(ent) && $stable(level)));

  a_r6_bottom_zero_fill: assert property (@(posedge clk) disable iff (rst)
    (pop && !push) |=> (ent[DEPTH-1] == '0));

  a_r8_level_bounded: assert property (@(posedge clk) disable iff (rst)
    (level <= LVL_W'(DEPTH)) && !(empty && full));
endmodule

bind register_chain_stack register_chain_stack_chk #(
  .WIDTH (WIDTH),
  .DEPTH (DEPTH)
) u_chk (
  .clk   (clk),
  .rst   (rst),
  .push  (push),
  .pop   (pop),
  .din   (din),
  .dout  (dout),
  .level (level),
  .empty (empty),
  .full  (full),
  .ent   (ent)
);

// File: tb/tb_register_chain_stack.sv
module tb_register_chain_stack;
  localparam int W  = 32;
  localparam int LW = 3;

  typedef struct packed {
    logic          psh;
    logic          pp;
    logic [W-1:0]  d;
    logic [W-1:0]  exp_q;
    logic [LW-1:0] exp_l;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 1'b0, 32'hA000_0001, 32'hA000_0001, 3'd1}, // R2
    '{1'b1, 1'b0, 32'hA000_0002, 32'hA000_0002, 3'd2}, // R2 R3
    '{1'b0, 1'b0, 32'hDEAD_0001, 32'hA000_0002, 3'd2}, // R5 neither
    '{1'b1, 1'b1, 32'hDEAD_0002, 32'hA000_0002, 3'd2}, // R5 both
    '{1'b1, 1'b0, 32'hA000_0003, 32'hA000_0003, 3'd3},
    '{1'b1, 1'b0, 32'hA000_0004, 32'hA000_0004, 3'd4}, // R8 full
    '{1'b1, 1'b0, 32'hA000_0005, 32'hA000_0005, 3'd4}, // R7 overfill
    '{1'b0, 1'b1, 32'hDEAD_0003, 32'hA000_0004, 3'd3}, // R4
    '{1'b0, 1'b1, 32'hDEAD_0004, 32'hA000_0003, 3'd2}, // R3 order
    '{1'b0, 1'b1, 32'hDEAD_0005, 32'hA000_0002, 3'd1},
    '{1'b0, 1'b1, 32'hDEAD_0006, 32'h0000_0000, 3'd0}, // R7 dropped word
    '{1'b0, 1'b1, 32'hDEAD_0007, 32'h0000_0000, 3'd0}, // R6 empty pop
    '{1'b1, 1'b0, 32'hB000_0001, 32'hB000_0001, 3'd1},
    '{1'b0, 1'b1, 32'hDEAD_0008, 32'h0000_0000, 3'd0}, // R6
    '{1'b1, 1'b0, 32'hC000_0001, 32'hC000_0001, 3'd1},
    '{1'b1, 1'b0, 32'hC000_0002, 32'hC000_0002, 3'd2},
    '{1'b0, 1'b1, 32'hDEAD_0009, 32'hC000_0001, 3'd1}  // R4
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          push = 1'b0;
  logic          pop = 1'b0;
  logic [W-1:0]  din = '0;
  logic [W-1:0]  dout;
  logic [LW-1:0] level;
  logic          empty;
  logic          full;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  register_chain_stack dut (
    .clk   (clk),
    .rst   (rst),
    .push  (push),
    .pop   (pop),
    .din   (din),
    .dout  (dout),
    .level (level),
    .empty (empty),
    .full  (full)
  );

  task automatic check_state(input string req, input logic [W-1:0] eq,
                             input logic [LW-1:0] el);
    checks++;
    if (dout !== eq || level !== el || empty !== (el == 0) || full !== (el == 4)) begin
      fails++;
      $display("FAIL %s: dout=%h level=%0d empty=%b full=%b expected dout=%h level=%0d empty=%b full=%b",
               req, dout, level, empty, full, eq, el, (el == 0), (el == 4));
    end
  endtask

  task automatic step(input logic p, input logic q, input logic [W-1:0] d);
    push = p; pop = q; din = d;
    @(negedge clk);
  endtask

  initial begin
    @(negedge clk);
    @(negedge clk);
    check_state("R1 reset state", '0, 0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      step(VECS[i].psh, VECS[i].pp, VECS[i].d);
      check_state($sformatf("R2/R3/R4/R5/R6/R7/R8 vector %0d", i),
                  VECS[i].exp_q, VECS[i].exp_l);
    end

    // R1: reset wins over a simultaneous push
    step(1'b1, 1'b0, 32'hE000_0001);
    check_state("R2 refill", 32'hE000_0001, 2);
    rst = 1'b1;
    step(1'b1, 1'b0, 32'hE000_0002);
    rst = 1'b0;
    check_state("R1 reset with push", '0, 0);
    step(1'b0, 1'b1, 32'h0);
    check_state("R6 pop after reset", '0, 0);

    // R8: flags never block; push while full still loads, pop while empty still runs
    for (int k = 0; k < 6; k++) step(1'b1, 1'b0, 32'hF000_0000 + W'(k));
    check_state("R8 saturate full", 32'hF000_0005, 4);
    step(1'b0, 1'b1, 32'h0);
    check_state("R7 pop after overfill", 32'hF000_0004, 3);
    step(1'b1, 1'b1, 32'h1234_5678);
    check_state("R5 both high", 32'hF000_0004, 3);

    push = 1'b0; pop = 1'b0;
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not end, actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule